// File: doc/BRIEF.md
# Receive Gain Code Mapper

This block holds the receive-path gain code and turns it into settings for two amplifier stages. The first is a coarse continuous-time stage that moves in 6 dB steps. The second is a fine switched-capacitor stage that moves in 2 dB steps. The total gain is -6 dB plus 2 dB per code step. The split between the two stages is not uniform. The lowest codes keep the coarse stage at its floor and use only the fine stage. The middle codes step the coarse stage once every three codes. The top codes depend on whether a wideband filter mode is active.

The gain code has two possible sources. A source-select input chooses between them. When it is high, a host write loads the code. When it is low, a strobe loads the code from a 5-bit data bus. The block reports the effective code, which is the code actually driving the stages after saturation and the wideband ceiling.

Encodings: `coarse_idx` = k means a coarse gain of -6 + 6k dB, with k from 0 to 5. `fine_idx` = m means a fine gain of 2m dB, with m from 0 to 6. `eff_code` = c means a total gain of -6 + 2c dB.

Top module: `rx_gain_mapper`

## Requirements
- R1: After a synchronous reset the held code is 0x00, so `eff_code`=0, `coarse_idx`=0 and `fine_idx`=0.
- R2: For codes 0x00 to 0x05, `coarse_idx` is 0 and `fine_idx` equals the code.
- R3: For codes 0x06 to 0x11, `coarse_idx` is 1 + (code-6)/3 and `fine_idx` is 3 + (code-6) mod 3.
- R4: With `wideband` low, codes 0x12 to 0x15 give `coarse_idx`=5 and `fine_idx`=3 + (code-18).
- R5: With `wideband` high, codes 0x12 to 0x15 give `coarse_idx`=4, `fine_idx`=6 and `eff_code`=0x12 (30 dB). Codes below 0x12 are mapped as they are with `wideband` low.
- R6: A loaded value above 0x15 is treated as 0x15.
- R7: With `src_sel_host` high, a cycle with `host_wr` high loads `host_wdata` at that clock edge. `gain_strobe` has no effect.
- R8: With `src_sel_host` low, a cycle with `gain_strobe` high loads `gain_bus` at that clock edge. `host_wr` has no effect. With no load, the code is held.
- R9: `eff_code` always reports the code in effect, after saturation and the wideband ceiling, whichever source loaded it. The sum of the stage gains equals -6 + 2*`eff_code` dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_host | input | 1 | 1: host writes supply the code; 0: the strobed bus supplies it |
| host_wr | input | 1 | Host write enable |
| host_wdata | input | 5 | Host write data (gain code) |
| gain_strobe | input | 1 | Pin-mode load strobe |
| gain_bus | input | 5 | Pin-mode gain code bus |
| wideband | input | 1 | Wideband filter mode (enables the 30 dB ceiling) |
| coarse_idx | output | 3 | Coarse stage setting, -6 + 6k dB |
| fine_idx | output | 3 | Fine stage setting, 2m dB |
| eff_code | output | 5 | Effective gain code, -6 + 2c dB |

## Verification
Every code from 0x00 to 0x15 is loaded once with `wideband` low and once with it high. This separates the three stage-split regions from one another and shows that the ceiling touches only the top four codes. Out-of-range values 0x16 and 0x1F are loaded to show the saturation. Loads are also tried through the wrong source for the current select: a host write in pin mode, and a strobe in host mode. In each case the output must stay unchanged, which tells apart the two load paths and the hold behaviour. The bench forms every expected value from total dB arithmetic, not from a copy of the mapping.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
    localparam int CODE_W   = 5;
    localparam int IDX_W    = 3;
    localparam int MAX_CODE = 21;
    localparam int CAP_CODE = 18;
    localparam int LOW_TOP  = 5;
    localparam int MID_TOP  = 17;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [IDX_W-1:0] coarse;
        logic [IDX_W-1:0] fine;
    } split_t;

    function automatic code_t sat_code(input code_t c);
        return (int'(c) > MAX_CODE) ? code_t'(MAX_CODE) : c;
    endfunction
endpackage

// File: rtl/rxg_source.sv
module rxg_source
    import rxg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_sel_host,
    input  logic  host_wr,
    input  code_t host_wdata,
    input  logic  gain_strobe,
    input  code_t gain_bus,
    output code_t code_q
);
    logic  load;
    code_t load_val;

    always_comb begin
        load     = src_sel_host ? host_wr : gain_strobe;
        load_val = sat_code(src_sel_host ? host_wdata : gain_bus);
    end

    always_ff @(posedge clk) begin
        if (rst)       code_q <= '0;
        else if (load) code_q <= load_val;
    end

    p_host_ignore_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (src_sel_host && !host_wr && gain_strobe) |=> $stable(code_q));
    p_pin_ignore_host_r8: assert property (@(posedge clk) disable iff (rst)
        (!src_sel_host && !gain_strobe && host_wr) |=> $stable(code_q));
    p_sat_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(code_q) <= MAX_CODE);
endmodule

// File: rtl/rxg_clamp.sv
module rxg_clamp
    import rxg_pkg::*;
(
    input  code_t code_in,
    input  logic  wideband,
    output code_t code_eff,
    output logic  capped
);
    always_comb begin
        capped   = wideband && (int'(code_in) >= CAP_CODE);
        code_eff = capped ? code_t'(CAP_CODE) : code_in;
    end
endmodule

// File: rtl/rxg_split.sv
module rxg_split
    import rxg_pkg::*;
(
    input  code_t  code_in,
    input  logic   capped,
    output split_t stages
);
    int unsigned c;
    int unsigned off;

    always_comb begin
        c   = int'(code_in);
        off = 0;
        stages = '0;
        if (capped) begin
            stages.coarse = IDX_W'(4);
            stages.fine   = IDX_W'(6);
        end else if (c <= LOW_TOP) begin
            stages.coarse = '0;
            stages.fine   = IDX_W'(c);
        end else if (c <= MID_TOP) begin
            off = c - (LOW_TOP + 1);
            stages.coarse = IDX_W'(1 + off / 3);
            stages.fine   = IDX_W'(3 + off % 3);
        end else begin
            stages.coarse = IDX_W'(5);
            stages.fine   = IDX_W'(3 + c - CAP_CODE);
        end
    end
endmodule

// File: rtl/rx_gain_mapper.sv
module rx_gain_mapper
    import rxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_sel_host,
    input  logic              host_wr,
    input  logic [CODE_W-1:0] host_wdata,
    input  logic              gain_strobe,
    input  logic [CODE_W-1:0] gain_bus,
    input  logic              wideband,
    output logic [IDX_W-1:0]  coarse_idx,
    output logic [IDX_W-1:0]  fine_idx,
    output logic [CODE_W-1:0] eff_code
);
    code_t  held;
    code_t  eff;
    logic   capped;
    split_t st;

    rxg_source u_src (
        .clk(clk), .rst(rst), .src_sel_host(src_sel_host),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .gain_strobe(gain_strobe), .gain_bus(gain_bus), .code_q(held)
    );

    rxg_clamp u_clamp (.code_in(held), .wideband(wideband),
                       .code_eff(eff), .capped(capped));

    rxg_split u_split (.code_in(eff), .capped(capped), .stages(st));

    assign coarse_idx = st.coarse;
    assign fine_idx   = st.fine;
    assign eff_code   = eff;

    p_gain_sum_r9: assert property (@(posedge clk) disable iff (rst)
        (6 * int'(coarse_idx) + 2 * int'(fine_idx)) == 2 * int'(eff_code));
    p_wide_cap_r5: assert property (@(posedge clk) disable iff (rst)
        wideband |-> (int'(eff_code) <= CAP_CODE));
    p_low_region_r2: assert property (@(posedge clk) disable iff (rst)
        (coarse_idx == '0) |-> (int'(fine_idx) <= LOW_TOP));
    p_fine_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (coarse_idx != '0) |-> (int'(fine_idx) >= 3));
endmodule

// File: tb/sim_rx_gain_mapper.sv
module sim_rx_gain_mapper;
    logic       clk = 0;
    logic       rst = 1;
    logic       src_sel_host = 0;
    logic       host_wr = 0;
    logic [4:0] host_wdata = 0;
    logic       gain_strobe = 0;
    logic [4:0] gain_bus = 0;
    logic       wideband = 0;
    logic [2:0] coarse_idx, fine_idx;
    logic [4:0] eff_code;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rx_gain_mapper u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected outputs from dB arithmetic
    task automatic check_code(input string req, input int code, input logic wb);
        int c, total, crs, fin;
        c = (code > 21) ? 21 : code;
        total = -6 + 2 * c;
        if (wb && total > 30) total = 30;
        if (total <= 4)        crs = -6;
        else if (total >= 32)  crs = 24;
        else if (wb && total == 30) crs = 18;
        else crs = ((total - 6) / 6) * 6;
        fin = total - crs;
        chk({req, " eff"},    int'(eff_code),   (total + 6) / 2);
        chk({req, " coarse"}, int'(coarse_idx), (crs + 6) / 6);
        chk({req, " fine"},   int'(fine_idx),   fin / 2);
    endtask

    task automatic pin_load(input int v);
        @(negedge clk); src_sel_host = 0; gain_bus = 5'(v); gain_strobe = 1;
        @(negedge clk); gain_strobe = 0;
    endtask

    task automatic host_load(input int v);
        @(negedge clk); src_sel_host = 1; host_wdata = 5'(v); host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic t_reset;
        check_code("R1 reset", 0, 0);
    endtask

    task automatic t_sweep(input logic wb);
        wideband = wb;
        for (int v = 0; v <= 21; v++) begin
            pin_load(v);
            if (v <= 5)       check_code("R2 low", v, wb);
            else if (v <= 17) check_code("R3 mid", v, wb);
            else if (wb)      check_code("R5 wide", v, wb);
            else              check_code("R4 top", v, wb);
        end
        wideband = 0;
    endtask

    task automatic t_saturate;
        pin_load(22);  check_code("R6 sat22", 22, 0);
        host_load(31); check_code("R6 sat31", 31, 0);
        wideband = 1; #1; check_code("R6 R5 sat wide", 31, 1);
        wideband = 0;
    endtask

    task automatic t_host;
        host_load(9); check_code("R7 host load", 9, 0);
        @(negedge clk); gain_bus = 5'd2; gain_strobe = 1;
        @(negedge clk); gain_strobe = 0;
        check_code("R7 strobe ignored", 9, 0);
        host_load(20); wideband = 1; #1;
        check_code("R9 host readback clamp", 20, 1);
        wideband = 0;
    endtask

    task automatic t_pin;
        pin_load(7); check_code("R8 pin load", 7, 0);
        @(negedge clk); src_sel_host = 0; host_wdata = 5'd15; host_wr = 1;
        @(negedge clk); host_wr = 0;
        check_code("R8 host ignored", 7, 0);
        @(negedge clk); gain_bus = 5'd12;
        @(negedge clk); @(negedge clk);
        check_code("R8 hold", 7, 0);
        pin_load(19); check_code("R9 pin readback", 19, 0);
    endtask

    initial begin
        fork
            begin
                repeat (2) @(negedge clk);
                rst = 0;
                t_reset();
                t_sweep(0);
                t_sweep(1);
                t_saturate();
                t_host();
                t_pin();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule